// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the feedback divide value (six bits) and the output divide code (two bits) that a clock synthesizer hands to its dividers. Software or board straps can set these values in two ways. The first way is a parallel pin path. While the parallel hold strobe is low, this path follows the pins. When the strobe rises, the path captures the pin values. The second way is a serial path. A 14-bit frame is clocked in on a data pin. A transfer strobe then moves the frame into the outputs, and while the strobe stays high the outputs follow each new shift.

All strobe, clock and data pins are asynchronous. They are resampled by a faster system clock through two-flop synchronizers, and every edge is detected on the resampled values. A master reset input forces the outputs to zero and freezes the shift register. When the master reset is released, the outputs take the present pin values, so pins that are hard-wired give a power-up default. A one-cycle update pulse tells the dividers to reload each time either output value changes.

Top module: `divcfg_loader`

## Requirements
- R1: While `mr` is high (and while `rst_n` is low), `m_val` and `n_code` read 0. They reach 0 no later than three `clk` edges after `mr` rises.
- R2: When `mr` is released, the outputs take the synchronized `pin_m`/`pin_n` values, whatever the level of `par_hold`.
- R3: While `par_hold` is low, `m_val`/`n_code` follow `pin_m`/`pin_n`, with a latency of three `clk` edges.
- R4: A rise of `par_hold` captures the pins. After that, pin changes have no effect while `par_hold` stays high and no serial transfer occurs.
- R5: While `par_hold` is high and `mr` is low, each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of a 14-bit shift register, and the older bits move one place toward bit 13.
- R6: Rising edges of `ser_clk` while `par_hold` is low or `mr` is high do not change the shift register.
- R7: A rise of `ser_xfer` while `par_hold` is high copies the frame fields to the outputs. The frame is sent first bit first: two zeros, one ignored bit, N1, N0, three ignored bits, then M5 down to M0. M is plain binary, so 13 is 001101 and 26 is 011010. In the register this places M at bits 5:0, N0 at bit 9 and N1 at bit 10.
- R8: While `ser_xfer` is low, and also after it falls, the outputs hold. Further shifts and pin changes do not alter them while `par_hold` is high.
- R9: While `ser_xfer` is high (with `par_hold` high), each rising edge of `ser_clk` updates the outputs from the frame fields of the shift register after that shift.
- R10: If a rise of `ser_xfer` and a rise of `ser_clk` are detected in the same `clk` cycle, the transfer includes the bit shifted in during that cycle.
- R11: `cfg_upd` is high for exactly one `clk` cycle, in the same cycle that `{m_val, n_code}` takes a new value. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Synchronous active-low reset |
| mr | input | 1 | Master reset, active high, asynchronous pin |
| pin_m | input | 6 | Parallel feedback divide value |
| pin_n | input | 2 | Parallel output divide code |
| par_hold | input | 1 | Low: pins are transparent; rising edge: capture |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial frame data |
| ser_xfer | input | 1 | Serial transfer strobe: rise copies, high passes through, fall holds |
| m_val | output | 6 | Registered feedback divide value |
| n_code | output | 2 | Registered output divide code |
| cfg_upd | output | 1 | One-cycle pulse when either output changes |

## Verification
A shift and a transfer can happen in the same cycle. This occurs when a rise of `ser_clk` and a rise of `ser_xfer` come out of the synchronizers together. To provoke it, the bench holds back the fourteenth frame bit and then raises both pins on the same falling `clk` edge. It then checks that the captured M value holds that last bit, and not the bit pattern from one shift earlier. A second overlap occurs when `mr` is released while `par_hold` is high. In that case the release load must win over the hold, and the bench checks that the pins appear at the outputs.

// File: rtl/divcfg_pkg.sv
// Package: shared widths, frame layout and the configuration word type
// for the divider configuration loader.
package divcfg_pkg;
    localparam int M_W         = 6;   // feedback divide value width
    localparam int N_W         = 2;   // output divide code width
    localparam int FRAME_LEN   = 14;  // serial frame length in bits
    localparam int GAP_W       = 3;   // ignored bits between N and M
    localparam int SYNC_STAGES = 2;   // synchronizer depth

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } div_cfg_t;
endpackage

// File: rtl/divcfg_sync.sv
// Module: divcfg_sync
// Brings a bank of asynchronous pins into the clk domain through a chain
// of STAGES flops. Assumes that each bit is used on its own, or that the
// bits of the bank change together, well apart from one another.
module divcfg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_chain
            // Each further stage retimes the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[k] <= RST_VAL;
                else        stage[k] <= stage[k-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
// Module: divcfg_shift
// Serial frame shift register. When en is high, din enters bit 0 and the
// older bits move toward the MSB. word_nx shows the value after this
// cycle's shift, so a transfer in the same cycle can include the new bit.
module divcfg_shift #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           din,
    output logic [LEN-1:0] word,
    output logic [LEN-1:0] word_nx
);
    // Next value: shifted when enabled, else unchanged.
    always_comb begin
        word_nx = en ? {word[LEN-2:0], din} : word;
    end

    // State register for the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= word_nx;
    end

    // R6: with no enable, the register keeps its value.
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(word));

    // R5: an enabled shift puts the sampled bit in bit 0.
    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (word[0] == $past(din)));
endmodule

// File: rtl/divcfg_loader.sv
// Module: divcfg_loader (top)
// Holds the feedback divide value and the output divide code. Sources are
// a parallel pin path (transparent while par_hold is low, captured on its
// rise) and a serial frame path (copied on a ser_xfer rise, passed through
// while it is high, held after it falls). Every pin is asynchronous to
// clk and is synchronized first. Each pin pulse must last longer than
// SYNC_STAGES+1 clk cycles.
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int MW     = M_W,
    parameter int NW     = N_W,
    parameter int FLEN   = FRAME_LEN,
    parameter int GAP    = GAP_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mr,
    input  logic [MW-1:0] pin_m,
    input  logic [NW-1:0] pin_n,
    input  logic          par_hold,
    input  logic          ser_clk,
    input  logic          ser_dat,
    input  logic          ser_xfer,
    output logic [MW-1:0] m_val,
    output logic [NW-1:0] n_code,
    output logic          cfg_upd
);
    localparam int CW     = MW + NW;
    localparam int N0_POS = MW + GAP;
    localparam int DW     = CW + 1;

    typedef struct packed {
        logic [MW-1:0] m;
        logic [NW-1:0] n;
    } cfg_t;

    // Synchronized controls: {mr, par_hold, ser_xfer, ser_clk}.
    // mr comes out of reset as asserted.
    logic [3:0] ctl_s;
    logic       mr_s, par_s, xfer_s, sclk_s;
    divcfg_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1000)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({mr, par_hold, ser_xfer, ser_clk}), .q(ctl_s)
    );
    assign {mr_s, par_s, xfer_s, sclk_s} = ctl_s;

    // Synchronized data: {ser_dat, pin_m, pin_n}.
    logic [DW-1:0] dat_bank;
    logic          dat_s;
    cfg_t          pin_s;
    divcfg_sync #(.W(DW), .STAGES(STAGES), .RST_VAL('0)) i_dat_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_dat, pin_m, pin_n}), .q(dat_bank)
    );
    assign dat_s = dat_bank[DW-1];
    assign pin_s = cfg_t'(dat_bank[CW-1:0]);

    // Previous synchronized levels for edge detection.
    logic mr_q, xfer_q, sclk_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_q   <= 1'b1;
            xfer_q <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            mr_q   <= mr_s;
            xfer_q <= xfer_s;
            sclk_q <= sclk_s;
        end
    end

    logic sclk_rise, xfer_rise, shift_en;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign xfer_rise = xfer_s & ~xfer_q;
    assign shift_en  = ~mr_s & par_s & sclk_rise;

    // Serial frame register.
    logic [FLEN-1:0] sr, sr_nx;
    divcfg_shift #(.LEN(FLEN)) i_shift (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .din(dat_s),
        .word(sr), .word_nx(sr_nx)
    );

    // Frame fields taken from the post-shift word.
    cfg_t frame_cfg;
    always_comb begin
        frame_cfg.m = sr_nx[MW-1:0];
        frame_cfg.n = sr_nx[N0_POS +: NW];
    end

    // Source selection, highest priority first.
    cfg_t cfg, cfg_nx;
    always_comb begin
        if (mr_s)                                   cfg_nx = '0;
        else if (mr_q)                              cfg_nx = pin_s;
        else if (!par_s)                            cfg_nx = pin_s;
        else if (xfer_s && (xfer_rise || sclk_rise)) cfg_nx = frame_cfg;
        else                                        cfg_nx = cfg;
    end

    // Output register and change pulse, in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            cfg_upd <= 1'b0;
        end else begin
            cfg     <= cfg_nx;
            cfg_upd <= (cfg_nx != cfg);
        end
    end

    assign m_val  = cfg.m;
    assign n_code = cfg.n;

    // R1: an asserted master reset clears the outputs.
    p_mr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mr_s |=> (cfg == '0));

    // R2: the release of master reset loads the pins.
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_q && !mr_s) |=> (cfg == $past(pin_s)));

    // R3: with the parallel path open, the outputs follow the pins.
    p_par_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_s && !mr_q && !par_s) |=> (cfg == $past(pin_s)));

    // R4 / R8: held with no transfer active, the outputs stay put.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_s && !mr_q && par_s && !xfer_s) |=> $stable(cfg));

    // R11: the pulse marks a change of the outputs exactly.
    p_upd_exact_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_upd == (cfg != $past(cfg))));
endmodule

// File: tb/test_divcfg_loader.sv
// Bench for divcfg_loader: a table of configuration vectors walked by one
// loop (parallel and serial loads), then directed tests for reset,
// freezing, pass-through and same-cycle shift/transfer.
module test_divcfg_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic [5:0] pin_m = 6'd13;
    logic [1:0] pin_n = 2'd1;
    logic       par_hold = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_xfer = 1'b0;
    logic [5:0] m_val;
    logic [1:0] n_code;
    logic       cfg_upd;

    int checks = 0;
    int fails = 0;
    int upd_cnt = 0;
    bit done = 0;
    logic [13:0] mdl = '0;   // expected shift register contents

    always #5 clk = ~clk;

    divcfg_loader i_divcfg_loader (
        .clk(clk), .rst_n(rst_n), .mr(mr), .pin_m(pin_m), .pin_n(pin_n),
        .par_hold(par_hold), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_xfer(ser_xfer), .m_val(m_val), .n_code(n_code), .cfg_upd(cfg_upd)
    );

    // Count update pulses away from the active edge.
    always @(negedge clk) if (cfg_upd) upd_cnt++;

    // Vectors: {M, N}.
    localparam logic [7:0] VEC [6] = '{
        {6'd13, 2'd0}, {6'd16, 2'd1}, {6'd26, 2'd3},
        {6'd63, 2'd2}, {6'd3,  2'd1}, {6'd32, 2'd0}
    };

    function automatic logic [13:0] mk_frame(input logic [7:0] v);
        return {2'b00, 1'b1, v[1], v[0], 3'b101, v[7:2]};
    endfunction

    function automatic logic [7:0] fields(input logic [13:0] w);
        return {w[5:0], w[10], w[9]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual m=%0d n=%0d expected m=%0d n=%0d",
                     req, act[7:2], act[1:0], exp[7:2], exp[1:0]);
        end
    endtask

    task automatic chk_cnt(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic counts);
        @(negedge clk);
        ser_dat = b;
        ser_clk = 1'b0;
        wait_n(3);
        ser_clk = 1'b1;
        if (counts) mdl = {mdl[12:0], b};
        wait_n(3);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [13:0] f, input int nbits);
        for (int b = 13; b > 13 - nbits; b--) send_bit(f[b], 1'b1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] cur, nxt, f8;
        int c0;
        wait_n(4);
        chk("R1 reset", {m_val, n_code}, 8'h00);
        rst_n = 1'b1;
        wait_n(5);
        chk("R2 power-up pins", {m_val, n_code}, {6'd13, 2'd1});
        cur = {6'd13, 2'd1};

        // Table walk: parallel load, capture, then serial load of the next vector.
        for (int i = 0; i < 6; i++) begin
            nxt = VEC[(i + 1) % 6];
            c0 = upd_cnt;
            @(negedge clk);
            par_hold = 1'b0;
            {pin_m, pin_n} = VEC[i];
            wait_n(5);
            chk("R3 transparent", {m_val, n_code}, VEC[i]);
            chk_cnt("R11 pulse count", upd_cnt - c0, (VEC[i] != cur) ? 1 : 0);
            par_hold = 1'b1;
            wait_n(5);
            c0 = upd_cnt;
            {pin_m, pin_n} = ~VEC[i];
            wait_n(5);
            chk("R4 captured", {m_val, n_code}, VEC[i]);
            chk_cnt("R11 no pulse", upd_cnt - c0, 0);
            send_frame(mk_frame(nxt), 14);
            wait_n(2);
            chk("R8 shift without transfer", {m_val, n_code}, VEC[i]);
            ser_xfer = 1'b1;
            wait_n(5);
            chk("R7 transfer", {m_val, n_code}, nxt);
            chk("R7 model", fields(mdl), nxt);
            ser_xfer = 1'b0;
            wait_n(5);
            chk("R8 after fall", {m_val, n_code}, nxt);
            cur = nxt;
        end

        // R9: pass-through while the transfer strobe stays high.
        @(negedge clk);
        ser_xfer = 1'b1;
        wait_n(5);
        chk("R9 transfer start", {m_val, n_code}, fields(mdl));
        for (int j = 0; j < 4; j++) begin
            send_bit(j[0], 1'b1);
            wait_n(2);
            chk("R9 pass-through", {m_val, n_code}, fields(mdl));
        end
        ser_xfer = 1'b0;
        wait_n(5);

        // R6: clocks while the parallel path is open do not shift.
        par_hold = 1'b0;
        {pin_m, pin_n} = {6'd40, 2'd2};
        for (int j = 0; j < 5; j++) send_bit(1'b1, 1'b0);
        par_hold = 1'b1;
        wait_n(5);
        ser_xfer = 1'b1;
        wait_n(5);
        chk("R6 frozen while open", {m_val, n_code}, fields(mdl));
        ser_xfer = 1'b0;
        wait_n(5);

        // R1 / R6 / R2: master reset clears, freezes, then loads pins on release.
        mr = 1'b1;
        wait_n(4);
        chk("R1 master reset", {m_val, n_code}, 8'h00);
        for (int j = 0; j < 5; j++) send_bit(1'b0, 1'b0);
        {pin_m, pin_n} = {6'd21, 2'd3};
        wait_n(2);
        chk("R1 held low", {m_val, n_code}, 8'h00);
        mr = 1'b0;
        wait_n(5);
        chk("R2 release load", {m_val, n_code}, {6'd21, 2'd3});
        ser_xfer = 1'b1;
        wait_n(5);
        chk("R6 frozen in reset", {m_val, n_code}, fields(mdl));
        ser_xfer = 1'b0;
        wait_n(5);

        // R10: last shift and transfer detected in the same cycle.
        f8 = {6'd27, 2'd2};
        send_frame(mk_frame(f8), 13);
        @(negedge clk);
        ser_dat = mk_frame(f8)[0];
        wait_n(2);
        ser_clk = 1'b1;
        ser_xfer = 1'b1;
        mdl = {mdl[12:0], mk_frame(f8)[0]};
        wait_n(5);
        chk("R10 same-cycle transfer", {m_val, n_code}, f8);
        ser_clk = 1'b0;
        ser_xfer = 1'b0;
        wait_n(5);
        chk("R10 held", {m_val, n_code}, f8);

        done = 1;
        summary();
    end
endmodule